// File: doc/BRIEF.md
# EPP Address/Data Cycle Translator

This block turns host register accesses into transfer cycles on an enhanced parallel port. The host sees two register addresses: an address port and a data port. A read or write to either one starts a peripheral cycle. The host operation sets the direction of the cycle. The register that was hit selects which control line is driven low: the select-in line for the address port, the autofeed line for the data port.

On a write, the write strobe is driven low and the host byte is placed on the peripheral bus. Both happen only when the direction input is low, which is the setting this mode requires. When the direction input is high, writes produce no strobe and the bus stays undriven. On a read, the bus is sampled at the cycle in which the host read strobe ends. The captured byte is then returned to the host. While the mode-enable input is low, host accesses have no effect and the read data is zero.

All peripheral outputs are registered. They follow the host inputs one clock later.

Top module: `epp_cycle_xlat`

## Requirements
- R1: One cycle after an enabled access to the address port (address 3, exactly one of read or write strobe high), `slctin_no` is 0. It is 1 after any other cycle.
- R2: One cycle after an enabled access to the data port (address 4, exactly one strobe high), `autofd_no` is 0. It is 1 after any other cycle.
- R3: One cycle after an enabled write to either port with `dir_i` = 0, `strobe_no` is 0. A read never pulls it low. A write with `dir_i` = 1 leaves it at 1.
- R4: `pd_oe_o` is 1 one cycle after exactly the cycles that drive `strobe_no` low. In that cycle `pd_o` equals the host write byte.
- R5: The read register loads `pd_i` in the first cycle in which an enabled read to either port is no longer present, given that one was present in the cycle before. At all other times it holds its value.
- R6: While `epp_en_i` is 0, no control line goes low, `pd_oe_o` stays 0 and `host_rdata_o` reads 0.
- R7: A cycle with both host strobes high, or with an address other than 3 or 4, starts no transfer.
- R8: After reset, `strobe_no`, `autofd_no` and `slctin_no` are 1, `pd_oe_o` is 0 and `host_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Host register address |
| rd_i | input | 1 | Host read strobe, active high |
| wr_i | input | 1 | Host write strobe, active high |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Captured peripheral byte; zero while disabled |
| epp_en_i | input | 1 | Enhanced mode enable |
| dir_i | input | 1 | Direction bit; 1 means input and blocks write strobes |
| pd_i | input | 8 | Peripheral bus input |
| pd_o | output | 8 | Peripheral bus output |
| pd_oe_o | output | 1 | Peripheral bus output enable |
| strobe_no | output | 1 | Write strobe, active low |
| autofd_no | output | 1 | Data-port select, active low |
| slctin_no | output | 1 | Address-port select, active low |

## Verification
The bench sweeps every combination of address, host strobe pair, enable and direction bit. This catches three kinds of error. A decoder that treats both strobes high as a write would raise a select line. An address compare that is too wide or too narrow would select on a neighbouring address. A design that ignores the direction bit would pulse the strobe and drive the bus during input mode.

Reads are placed back to back, so the capture point gets tested. A design that samples at the start of the strobe, or on every cycle of it, loads the wrong bus byte. Turning the mode off in the middle of the sequence shows whether the read data is really gated to zero, or whether a stale byte leaks through.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2
  } port_sel_e;
endpackage

// File: rtl/epp_decode.sv
module epp_decode
  import epp_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int ADDR_PORT = 3,
  parameter int DATA_PORT = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              en_i,
  output port_sel_e         sel_o,
  output logic              is_wr_o,
  output logic              is_rd_o
);
  localparam logic [ADDR_W-1:0] APORT = ADDR_W'(ADDR_PORT);
  localparam logic [ADDR_W-1:0] DPORT = ADDR_W'(DATA_PORT);

  logic op_ok;
  assign op_ok = en_i & (rd_i ^ wr_i);

  always_comb begin
    sel_o = SEL_NONE;
    if (op_ok && addr_i == APORT)      sel_o = SEL_ADDR;
    else if (op_ok && addr_i == DPORT) sel_o = SEL_DATA;
  end

  assign is_wr_o = (sel_o != SEL_NONE) & wr_i;
  assign is_rd_o = (sel_o != SEL_NONE) & rd_i;
endmodule

// File: rtl/epp_strobe_gen.sv
module epp_strobe_gen
  import epp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  port_sel_e         sel_i,
  input  logic              is_wr_i,
  input  logic              dir_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] pd_o,
  output logic              pd_oe_o,
  output logic              strobe_no,
  output logic              autofd_no,
  output logic              slctin_no
);
  logic drive;
  assign drive = is_wr_i & ~dir_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_o      <= '0;
      pd_oe_o   <= 1'b0;
      strobe_no <= 1'b1;
      autofd_no <= 1'b1;
      slctin_no <= 1'b1;
    end else begin
      slctin_no <= (sel_i != SEL_ADDR);
      autofd_no <= (sel_i != SEL_DATA);
      strobe_no <= ~drive;
      pd_oe_o   <= drive;
      if (drive) pd_o <= wdata_i;
    end
  end
endmodule

// File: rtl/epp_rd_capture.sv
module epp_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              is_rd_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] pd_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              rd_q;
  logic [DATA_W-1:0] cap_q;

  // sample the bus on the cycle the read strobe is released
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      cap_q <= '0;
    end else begin
      rd_q <= is_rd_i;
      if (rd_q && !is_rd_i) cap_q <= pd_i;
    end
  end

  assign rdata_o = en_i ? cap_q : '0;
endmodule

// File: rtl/epp_cycle_xlat.sv
module epp_cycle_xlat
  import epp_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int ADDR_PORT = 3,
  parameter int DATA_PORT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              epp_en_i,
  input  logic              dir_i,
  input  logic [DATA_W-1:0] pd_i,
  output logic [DATA_W-1:0] pd_o,
  output logic              pd_oe_o,
  output logic              strobe_no,
  output logic              autofd_no,
  output logic              slctin_no
);
  port_sel_e sel;
  logic      is_wr, is_rd;

  epp_decode #(
    .ADDR_W(ADDR_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
  ) u_dec (
    .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .en_i(epp_en_i),
    .sel_o(sel), .is_wr_o(is_wr), .is_rd_o(is_rd)
  );

  epp_strobe_gen #(.DATA_W(DATA_W)) u_stb (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .is_wr_i(is_wr),
    .dir_i(dir_i), .wdata_i(host_wdata_i), .pd_o(pd_o), .pd_oe_o(pd_oe_o),
    .strobe_no(strobe_no), .autofd_no(autofd_no), .slctin_no(slctin_no)
  );

  epp_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .is_rd_i(is_rd), .en_i(epp_en_i),
    .pd_i(pd_i), .rdata_o(host_rdata_o)
  );
endmodule

// File: rtl/epp_cycle_xlat_chk.sv
module epp_cycle_xlat_chk #(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int ADDR_PORT = 3,
  parameter int DATA_PORT = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] host_wdata_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic              epp_en_i,
  input logic              dir_i,
  input logic [DATA_W-1:0] pd_o,
  input logic              pd_oe_o,
  input logic              strobe_no,
  input logic              autofd_no,
  input logic              slctin_no
);
  logic wr_go;
  assign wr_go = epp_en_i & wr_i & ~rd_i & ~dir_i &
                 (addr_i == ADDR_W'(ADDR_PORT) || addr_i == ADDR_W'(DATA_PORT));

  AST_ONE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slctin_no || autofd_no); // R1

  AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no |-> (!slctin_no || !autofd_no)); // R3

  AST_OE_WITH_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_oe_o |-> !strobe_no); // R4

  AST_WRITE_DRIVES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go |=> (pd_oe_o && pd_o == $past(host_wdata_i))); // R4

  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epp_en_i |=> (slctin_no && autofd_no && strobe_no && !pd_oe_o)); // R6

  AST_DISABLED_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epp_en_i |-> host_rdata_o == '0); // R6

  AST_BOTH_STROBES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i) |=> (slctin_no && autofd_no && strobe_no)); // R7
endmodule

bind epp_cycle_xlat epp_cycle_xlat_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
  .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o), .epp_en_i(epp_en_i),
  .dir_i(dir_i), .pd_o(pd_o), .pd_oe_o(pd_oe_o), .strobe_no(strobe_no),
  .autofd_no(autofd_no), .slctin_no(slctin_no)
);

// File: tb/tb_epp_cycle_xlat.sv
`timescale 1ns/1ps
module tb_epp_cycle_xlat;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0, en = 1'b0, dir = 1'b0;
  logic [7:0] wdata = '0, rdata, pd_in = '0, pd_out;
  logic       oe, stb_n, afd_n, sel_n;
  int         n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  epp_cycle_xlat dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .epp_en_i(en), .dir_i(dir),
    .pd_i(pd_in), .pd_o(pd_out), .pd_oe_o(oe), .strobe_no(stb_n),
    .autofd_no(afd_n), .slctin_no(sel_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] exp_cap;
    logic       prev_rd;
    exp_cap = '0;
    prev_rd = 1'b0;
    repeat (2) @(negedge clk);
    // R8 reset state
    chk("R8 strobe_no", {7'd0, stb_n}, 8'd1);
    chk("R8 autofd_no", {7'd0, afd_n}, 8'd1);
    chk("R8 slctin_no", {7'd0, sel_n}, 8'd1);
    chk("R8 pd_oe_o", {7'd0, oe}, 8'd0);
    chk("R8 host_rdata_o", rdata, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 128; i++) begin
        logic op, ha, hd, wgo, rhit;
        addr  = i[2:0];
        rd    = i[3];
        wr    = i[4];
        en    = ~i[5];
        dir   = i[6];
        wdata = 8'((i * 29 + p * 71 + 5) & 255);
        pd_in = 8'((i * 37 + p * 13 + 1) & 255);
        op   = en & (rd ^ wr);
        ha   = op & (addr == 3'd3);
        hd   = op & (addr == 3'd4);
        wgo  = (ha | hd) & wr & ~dir;
        rhit = (ha | hd) & rd;
        if (prev_rd && !rhit) exp_cap = pd_in;
        prev_rd = rhit;
        @(posedge clk);
        @(negedge clk);
        if (!en) begin
          chk("R6 idle lines", {5'd0, stb_n, afd_n, sel_n}, 8'h07);
          chk("R6 oe", {7'd0, oe}, 8'd0);
          chk("R6 rdata zero", rdata, 8'd0);
        end else if (!ha && !hd) begin
          chk("R7 idle lines", {5'd0, stb_n, afd_n, sel_n}, 8'h07);
          chk("R7 oe", {7'd0, oe}, 8'd0);
          chk("R5 rdata hold", rdata, exp_cap);
        end else begin
          chk("R1 slctin_no", {7'd0, sel_n}, {7'd0, ~ha});
          chk("R2 autofd_no", {7'd0, afd_n}, {7'd0, ~hd});
          chk("R3 strobe_no", {7'd0, stb_n}, {7'd0, ~wgo});
          chk("R4 pd_oe_o", {7'd0, oe}, {7'd0, wgo});
          if (wgo) chk("R4 pd_o", pd_out, wdata);
          chk("R5 rdata", rdata, exp_cap);
        end
      end
    end

    // R5 directed: multi-cycle read, capture only at release
    en = 1'b1; dir = 1'b0; wr = 1'b0; rd = 1'b1; addr = 3'd4; pd_in = 8'hA5;
    repeat (3) @(negedge clk);
    chk("R5 no capture mid-read", rdata, exp_cap);
    rd = 1'b0; pd_in = 8'h3C;
    @(negedge clk);
    pd_in = 8'hFF;
    chk("R5 capture at release", rdata, 8'h3C);
    @(negedge clk);
    chk("R5 hold after release", rdata, 8'h3C);
    en = 1'b0;
    #1;
    chk("R6 rdata gated", rdata, 8'd0);
    en = 1'b1;
    #1;
    chk("R5 value kept while gated", rdata, 8'h3C);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule